// File: doc/BRIEF.md
# Memory-Mapped I/O Bridge with Deferred Completion

The bridge sits between a multi-threaded core's load/store stage and an external I/O handler. Each cycle it checks the request's byte address and byte size against a parameterised I/O window. It forwards an in-window request from an idle thread to the handler in the same cycle. The handler either acknowledges at once, in which case the access completes in that cycle, or leaves the access open. An open access is closed later by a tagged event on one of two channels: a load-result channel that carries a thread index and a data word, and a store-done channel that carries only a thread index.

The bridge keeps one outstanding access per thread and raises a stall for that thread only, for as long as its access is open. It does not forward a new in-window request from a thread that is still waiting. A completion event that matches no open access of the same kind is dropped, and a sticky error flag records it. If the window length is zero, the I/O path is disabled. By default the window starts right after the data-memory region.

Top module: `mmio_bridge`

## Requirements
- R1: A request hits the window (`mmio_hit_o`=1) only when every byte of it, from `req_addr_i` to `req_addr_i+req_size_i-1`, lies inside [base, base+length). `req_size_i` is a byte count and must not be 0.
- R2: When the window length is 0, `mmio_hit_o` and `hnd_valid_o` stay 0 for every request.
- R3: With the default base, the window begins at data-memory base plus data-memory size. With data base 0x1000 and size 0x100, address 0x10FF misses and address 0x1100 hits.
- R4: An in-window request from a thread with no open access drives `hnd_valid_o` in the same cycle. Thread, store flag, address, size and write data pass through unchanged.
- R5: When `hnd_ack_i` is high with `hnd_valid_o`, `imm_done_o` is 1 in that cycle. `imm_rdata_o` equals `hnd_rdata_i` for a load and is 0 for a store.
- R6: A forwarded request without acknowledge opens an access for its thread. `stall_o[t]` goes high in the issue cycle and stays high until the cycle after completion. No other thread's stall bit changes.
- R7: A load-result event whose thread has an open load asserts `late_ld_done_o` in the same cycle, with that thread and data on `late_ld_tid_o`/`late_ld_rdata_o`. The thread's stall clears on the next cycle.
- R8: A store-done event whose thread has an open store asserts `late_st_done_o` in the same cycle. The thread's stall clears on the next cycle.
- R9: An in-window request from a thread with an open access is not forwarded, and that thread stays stalled.
- R10: A completion event for a thread with no open access, or with an open access of the other kind, gives no done pulse. It sets `err_o` on the next cycle, and `err_o` stays set until reset.
- R11: After reset no access is open, `stall_o` is 0 and `err_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Core load/store request |
| req_tid_i | input | TID_W | Requesting thread |
| req_store_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | ADDR_W | Byte address |
| req_size_i | input | SIZE_W | Access size in bytes |
| req_wdata_i | input | DATA_W | Store data |
| mmio_hit_o | output | 1 | Request falls inside the I/O window |
| stall_o | output | THREADS | Per-thread stall |
| imm_done_o | output | 1 | Same-cycle completion |
| imm_rdata_o | output | DATA_W | Same-cycle load data |
| hnd_valid_o | output | 1 | Request to handler |
| hnd_tid_o | output | TID_W | Thread of handler request |
| hnd_store_o | output | 1 | Store flag to handler |
| hnd_addr_o | output | ADDR_W | Address to handler |
| hnd_size_o | output | SIZE_W | Size to handler |
| hnd_wdata_o | output | DATA_W | Store data to handler |
| hnd_ack_i | input | 1 | Handler completes in this cycle |
| hnd_rdata_i | input | DATA_W | Handler load data |
| ld_cpl_valid_i | input | 1 | Deferred load-result event |
| ld_cpl_tid_i | input | TID_W | Thread of load-result event |
| ld_cpl_data_i | input | DATA_W | Deferred load data |
| st_cpl_valid_i | input | 1 | Deferred store-done event |
| st_cpl_tid_i | input | TID_W | Thread of store-done event |
| late_ld_done_o | output | 1 | Deferred load completed |
| late_ld_tid_o | output | TID_W | Thread of completed load |
| late_ld_rdata_o | output | DATA_W | Deferred load data to core |
| late_st_done_o | output | 1 | Deferred store completed |
| late_st_tid_o | output | TID_W | Thread of completed store |
| err_o | output | 1 | Sticky unmatched-completion flag |

## Verification
The bench targets the window edges. An access that starts inside but runs past the end must miss, and an off-by-one decoder would forward it. It also drives completion events of the wrong kind or for idle threads. A design that matched only on thread index would release a stalled store on a load result, or pulse a done for a thread that never issued. It also sends repeat requests from waiting threads, which a tracker without hold-back would forward twice. Stall timing is compared on every cycle, so a stall that rises one cycle late or clears one cycle early shows up as a mismatch.

// File: rtl/mmio_bridge_pkg.sv
package mmio_bridge_pkg;
  typedef enum logic {
    ACC_LOAD  = 1'b0,
    ACC_STORE = 1'b1
  } acc_kind_e;

  typedef struct packed {
    logic      busy;
    acc_kind_e kind;
  } slot_t;
endpackage

// File: rtl/mmio_window_dec.sv
module mmio_window_dec #(
  parameter int unsigned          ADDR_W = 32,
  parameter int unsigned          SIZE_W = 3,
  parameter logic [ADDR_W-1:0]    BASE   = '0,
  parameter int unsigned          LEN    = 0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic              hit_o
);
  generate
    if (LEN == 0) begin : g_off
      logic unused_ok;
      assign unused_ok = ^{addr_i, size_i};
      assign hit_o     = 1'b0;
    end else begin : g_on
      localparam logic [ADDR_W:0] LEN_X = (ADDR_W+1)'(LEN);
      logic [ADDR_W:0] off, end_x;
      assign off   = {1'b0, addr_i} - {1'b0, BASE};
      assign end_x = off + (ADDR_W+1)'(size_i);
      // whole access must fit; size 0 never hits
      assign hit_o = (addr_i >= BASE) && (size_i != '0) && (end_x <= LEN_X);
    end
  endgenerate
endmodule

// File: rtl/mmio_pend_tracker.sv
module mmio_pend_tracker
  import mmio_bridge_pkg::*;
#(
  parameter int unsigned THREADS = 4,
  parameter int unsigned TID_W   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               issue_i,
  input  logic [TID_W-1:0]   issue_tid_i,
  input  logic               issue_store_i,
  input  logic               ld_cpl_valid_i,
  input  logic [TID_W-1:0]   ld_cpl_tid_i,
  input  logic               st_cpl_valid_i,
  input  logic [TID_W-1:0]   st_cpl_tid_i,
  output logic [THREADS-1:0] busy_o,
  output logic               ld_match_o,
  output logic               st_match_o,
  output logic               err_o
);
  slot_t slot_q [THREADS];
  logic  err_q;

  assign ld_match_o = ld_cpl_valid_i && slot_q[ld_cpl_tid_i].busy &&
                      (slot_q[ld_cpl_tid_i].kind == ACC_LOAD);
  assign st_match_o = st_cpl_valid_i && slot_q[st_cpl_tid_i].busy &&
                      (slot_q[st_cpl_tid_i].kind == ACC_STORE);

  generate
    for (genvar t = 0; t < THREADS; t++) begin : g_slot
      logic set_t, clr_t;
      assign set_t = issue_i && (issue_tid_i == TID_W'(t));
      assign clr_t = (ld_match_o && (ld_cpl_tid_i == TID_W'(t))) ||
                     (st_match_o && (st_cpl_tid_i == TID_W'(t)));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          slot_q[t] <= '{busy: 1'b0, kind: ACC_LOAD};
        end else if (set_t) begin
          slot_q[t] <= '{busy: 1'b1, kind: issue_store_i ? ACC_STORE : ACC_LOAD};
        end else if (clr_t) begin
          slot_q[t].busy <= 1'b0;
        end
      end
      assign busy_o[t] = slot_q[t].busy;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else if ((ld_cpl_valid_i && !ld_match_o) || (st_cpl_valid_i && !st_match_o))
      err_q <= 1'b1;
  end
  assign err_o = err_q;

  a_r6_defer_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |=> busy_o[$past(issue_tid_i)]);
  a_r7_load_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_match_o |=> !busy_o[$past(ld_cpl_tid_i)]);
  a_r8_store_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_match_o |=> !busy_o[$past(st_cpl_tid_i)]);
  a_r10_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

// File: rtl/mmio_bridge.sv
module mmio_bridge #(
  parameter int unsigned       THREADS    = 4,
  parameter int unsigned       ADDR_W     = 32,
  parameter int unsigned       DATA_W     = 32,
  parameter int unsigned       SIZE_W     = 3,
  parameter logic [ADDR_W-1:0] DMEM_BASE  = 32'h0000_1000,
  parameter int unsigned       DMEM_SIZE  = 32'h100,
  parameter int unsigned       MMIO_LEN   = 64,
  parameter logic [ADDR_W-1:0] MMIO_BASE  = DMEM_BASE + ADDR_W'(DMEM_SIZE),
  localparam int unsigned      TID_W      = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [TID_W-1:0]   req_tid_i,
  input  logic               req_store_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [SIZE_W-1:0]  req_size_i,
  input  logic [DATA_W-1:0]  req_wdata_i,
  output logic               mmio_hit_o,
  output logic [THREADS-1:0] stall_o,
  output logic               imm_done_o,
  output logic [DATA_W-1:0]  imm_rdata_o,
  output logic               hnd_valid_o,
  output logic [TID_W-1:0]   hnd_tid_o,
  output logic               hnd_store_o,
  output logic [ADDR_W-1:0]  hnd_addr_o,
  output logic [SIZE_W-1:0]  hnd_size_o,
  output logic [DATA_W-1:0]  hnd_wdata_o,
  input  logic               hnd_ack_i,
  input  logic [DATA_W-1:0]  hnd_rdata_i,
  input  logic               ld_cpl_valid_i,
  input  logic [TID_W-1:0]   ld_cpl_tid_i,
  input  logic [DATA_W-1:0]  ld_cpl_data_i,
  input  logic               st_cpl_valid_i,
  input  logic [TID_W-1:0]   st_cpl_tid_i,
  output logic               late_ld_done_o,
  output logic [TID_W-1:0]   late_ld_tid_o,
  output logic [DATA_W-1:0]  late_ld_rdata_o,
  output logic               late_st_done_o,
  output logic [TID_W-1:0]   late_st_tid_o,
  output logic               err_o
);
  logic               win_hit, fwd, defer;
  logic [THREADS-1:0] busy;

  mmio_window_dec #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .BASE(MMIO_BASE), .LEN(MMIO_LEN)
  ) u_dec (
    .addr_i(req_addr_i), .size_i(req_size_i), .hit_o(win_hit)
  );

  mmio_pend_tracker #(.THREADS(THREADS), .TID_W(TID_W)) u_trk (
    .clk_i, .rst_ni,
    .issue_i        (defer),
    .issue_tid_i    (req_tid_i),
    .issue_store_i  (req_store_i),
    .ld_cpl_valid_i, .ld_cpl_tid_i,
    .st_cpl_valid_i, .st_cpl_tid_i,
    .busy_o         (busy),
    .ld_match_o     (late_ld_done_o),
    .st_match_o     (late_st_done_o),
    .err_o
  );

  assign mmio_hit_o  = req_valid_i && win_hit;
  // hold back a thread that still waits
  assign fwd         = mmio_hit_o && !busy[req_tid_i];
  assign defer       = fwd && !hnd_ack_i;

  assign hnd_valid_o = fwd;
  assign hnd_tid_o   = req_tid_i;
  assign hnd_store_o = req_store_i;
  assign hnd_addr_o  = req_addr_i;
  assign hnd_size_o  = req_size_i;
  assign hnd_wdata_o = req_wdata_i;

  assign imm_done_o  = fwd && hnd_ack_i;
  assign imm_rdata_o = (imm_done_o && !req_store_i) ? hnd_rdata_i : '0;

  assign late_ld_tid_o   = ld_cpl_tid_i;
  assign late_ld_rdata_o = ld_cpl_data_i;
  assign late_st_tid_o   = st_cpl_tid_i;

  always_comb begin
    stall_o = busy;
    if (defer) stall_o[req_tid_i] = 1'b1;
  end

  a_r5_imm_leaves_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imm_done_o |=> !busy[$past(hnd_tid_o)]);
  a_r9_no_double_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mmio_hit_o && $past(defer) && (req_tid_i == $past(req_tid_i))) |-> !hnd_valid_o);
endmodule

// File: tb/tb_mmio_bridge.sv
module tb_mmio_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int THREADS = 4;
  localparam logic [31:0] DBASE = 32'h1000;
  localparam int DSIZE = 32'h100;
  localparam int WLEN  = 64;
  localparam longint WBASE = 64'h1100;

  logic clk = 0, rst_ni = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic req_valid = 0, req_store = 0, hnd_ack = 0, ld_v = 0, st_v = 0;
  logic [1:0] req_tid = 0, ld_tid = 0, st_tid = 0;
  logic [31:0] req_addr = 0, req_wdata = 0, hnd_rdata = 0, ld_data = 0;
  logic [2:0] req_size = 0;

  logic mmio_hit, imm_done, hnd_valid, hnd_store, late_ld_done, late_st_done, err;
  logic [3:0] stall;
  logic [31:0] imm_rdata, hnd_addr, hnd_wdata, late_ld_rdata;
  logic [1:0] hnd_tid, late_ld_tid, late_st_tid;
  logic [2:0] hnd_size;

  logic off_hit, off_valid, off_imm, off_ldd, off_std, off_err;
  logic [3:0] off_stall;
  logic [31:0] off_ird, off_addr, off_wd, off_lrd;
  logic [1:0] off_tid, off_lt, off_st;
  logic [2:0] off_size;
  logic off_store;

  mmio_bridge #(.THREADS(THREADS), .DMEM_BASE(DBASE), .DMEM_SIZE(DSIZE), .MMIO_LEN(WLEN)) dut (
    .clk_i(clk), .rst_ni, .req_valid_i(req_valid), .req_tid_i(req_tid), .req_store_i(req_store),
    .req_addr_i(req_addr), .req_size_i(req_size), .req_wdata_i(req_wdata),
    .mmio_hit_o(mmio_hit), .stall_o(stall), .imm_done_o(imm_done), .imm_rdata_o(imm_rdata),
    .hnd_valid_o(hnd_valid), .hnd_tid_o(hnd_tid), .hnd_store_o(hnd_store), .hnd_addr_o(hnd_addr),
    .hnd_size_o(hnd_size), .hnd_wdata_o(hnd_wdata), .hnd_ack_i(hnd_ack), .hnd_rdata_i(hnd_rdata),
    .ld_cpl_valid_i(ld_v), .ld_cpl_tid_i(ld_tid), .ld_cpl_data_i(ld_data),
    .st_cpl_valid_i(st_v), .st_cpl_tid_i(st_tid),
    .late_ld_done_o(late_ld_done), .late_ld_tid_o(late_ld_tid), .late_ld_rdata_o(late_ld_rdata),
    .late_st_done_o(late_st_done), .late_st_tid_o(late_st_tid), .err_o(err));

  mmio_bridge #(.THREADS(THREADS), .DMEM_BASE(DBASE), .DMEM_SIZE(DSIZE), .MMIO_LEN(0)) dut_off (
    .clk_i(clk), .rst_ni, .req_valid_i(req_valid), .req_tid_i(req_tid), .req_store_i(req_store),
    .req_addr_i(req_addr), .req_size_i(req_size), .req_wdata_i(req_wdata),
    .mmio_hit_o(off_hit), .stall_o(off_stall), .imm_done_o(off_imm), .imm_rdata_o(off_ird),
    .hnd_valid_o(off_valid), .hnd_tid_o(off_tid), .hnd_store_o(off_store), .hnd_addr_o(off_addr),
    .hnd_size_o(off_size), .hnd_wdata_o(off_wd), .hnd_ack_i(hnd_ack), .hnd_rdata_i(hnd_rdata),
    .ld_cpl_valid_i(1'b0), .ld_cpl_tid_i(ld_tid), .ld_cpl_data_i(ld_data),
    .st_cpl_valid_i(1'b0), .st_cpl_tid_i(st_tid),
    .late_ld_done_o(off_ldd), .late_ld_tid_o(off_lt), .late_ld_rdata_o(off_lrd),
    .late_st_done_o(off_std), .late_st_tid_o(off_st), .err_o(off_err));

  int n_cmp = 0, n_bad = 0;
  bit pend[THREADS];
  bit pst[THREADS];
  bit m_err = 0;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit inwin(logic [31:0] a, int sz);
    longint la = longint'(a);
    if (sz == 0) return 0;
    return (la >= WBASE) && (la - WBASE + sz <= WLEN);
  endfunction

  task automatic step(bit v, int tid, bit st, logic [31:0] a, int sz, logic [31:0] wd,
                      bit ack, logic [31:0] rd, bit lv, int lt, logic [31:0] ldd,
                      bit sv, int stt);
    bit hit, fwd, defer, ldone, sdone;
    logic [3:0] exp_stall;
    @(negedge clk);
    req_valid = v; req_tid = 2'(tid); req_store = st; req_addr = a; req_size = 3'(sz);
    req_wdata = wd; hnd_ack = ack; hnd_rdata = rd; ld_v = lv; ld_tid = 2'(lt);
    ld_data = ldd; st_v = sv; st_tid = 2'(stt);
    #1;
    hit   = v && inwin(a, sz);
    fwd   = hit && !pend[tid];
    defer = fwd && !ack;
    ldone = lv && pend[lt] && !pst[lt];
    sdone = sv && pend[stt] && pst[stt];
    exp_stall = '0;
    for (int t = 0; t < THREADS; t++) exp_stall[t] = pend[t];
    if (defer) exp_stall[tid] = 1'b1;

    chk("R1", "mmio_hit", mmio_hit, hit);
    chk((hit && pend[tid]) ? "R9" : "R4", "hnd_valid", hnd_valid, fwd);
    if (fwd) begin
      chk("R4", "hnd_tid", hnd_tid, tid);
      chk("R4", "hnd_store", hnd_store, st);
      chk("R4", "hnd_addr", hnd_addr, a);
      chk("R4", "hnd_size", hnd_size, sz);
      chk("R4", "hnd_wdata", hnd_wdata, wd);
    end
    chk("R5", "imm_done", imm_done, fwd && ack);
    chk("R5", "imm_rdata", imm_rdata, (fwd && ack && !st) ? rd : 32'h0);
    chk("R6", "stall", stall, exp_stall);
    chk("R7", "late_ld_done", late_ld_done, ldone);
    if (ldone) begin
      chk("R7", "late_ld_tid", late_ld_tid, lt);
      chk("R7", "late_ld_rdata", late_ld_rdata, ldd);
    end
    chk("R8", "late_st_done", late_st_done, sdone);
    if (sdone) chk("R8", "late_st_tid", late_st_tid, stt);
    chk("R10", "err", err, m_err);
    chk("R2", "off_hit", off_hit, 0);
    chk("R2", "off_valid", off_valid, 0);

    if (defer) begin pend[tid] = 1; pst[tid] = st; end
    if (ldone) pend[lt] = 0;
    if (sdone) pend[stt] = 0;
    if ((lv && !ldone) || (sv && !sdone)) m_err = 1;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    int addrs[8];
    int sizes[3];
    addrs = '{32'h10FF, 32'h1100, 32'h1104, 32'h113C, 32'h113D, 32'h1140, 32'h0800, 32'h1120};
    sizes = '{1, 2, 4};
    for (int t = 0; t < THREADS; t++) begin pend[t] = 0; pst[t] = 0; end
    repeat (3) @(posedge clk);
    #2 rst_ni = 1;
    @(negedge clk); #1;
    chk("R11", "stall after reset", stall, 0);
    chk("R11", "err after reset", err, 0);

    step(1, 0, 0, 32'h10FF, 1, 0, 1, 32'hAA, 0, 0, 0, 0, 0);
    chk("R3", "hit below default base", mmio_hit, 0);
    step(1, 0, 0, 32'h1100, 1, 0, 1, 32'hA5A5, 0, 0, 0, 0, 0);
    chk("R3", "hit at default base", mmio_hit, 1);
    step(1, 1, 1, 32'h113C, 4, 32'h1234, 1, 32'hFFFF, 0, 0, 0, 0, 0);
    step(1, 1, 0, 32'h113D, 4, 0, 1, 0, 0, 0, 0, 0, 0);
    step(1, 1, 0, 32'h1140, 1, 0, 1, 0, 0, 0, 0, 0, 0);
    // deferred load on thread 1, retry held, spurious, then completion
    step(1, 1, 0, 32'h1108, 4, 0, 0, 0, 0, 0, 0, 0, 0);
    step(1, 1, 0, 32'h1108, 4, 0, 1, 32'h77, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0, 0, 1, 2, 32'hDEAD, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0, 0, 1, 1, 32'hBEEF, 0, 0);
    idle();
    // deferred store on thread 3, wrong-kind event, then store done
    step(1, 3, 1, 32'h1110, 2, 32'h55, 0, 32'h99, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0, 0, 1, 3, 32'h11, 0, 0);
    step(1, 2, 0, 32'h1120, 1, 0, 0, 0, 0, 0, 0, 1, 3);
    step(0, 0, 0, 0, 1, 0, 0, 0, 1, 2, 32'h4242, 0, 0);
    idle();

    for (int i = 0; i < 3000; i++) begin
      int tid, lt, stt;
      bit lv, sv;
      tid = int'($urandom % THREADS);
      lt  = int'($urandom % THREADS);
      stt = int'($urandom % THREADS);
      lv  = ($urandom % 4) == 0;
      sv  = ($urandom % 4) == 0;
      step(($urandom % 10) < 6, tid, $urandom % 2, addrs[$urandom % 8], sizes[$urandom % 3],
           $urandom, $urandom % 2, $urandom, lv, lt, $urandom, sv, stt);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule